// File: doc/BRIEF.md
# Parallel AND-and-Store Execute Stage

This block executes one dual-operation instruction word in a single clock. In that cycle it does two things. It forms the bitwise AND of an integer register and a word read from memory through an indirect address, and writes the result to a destination register. It also stores a second integer register to another indirectly addressed memory word. Both effective addresses come from an auxiliary register selected by the instruction, plus a small displacement. The displacement can be 0, 1, or one of two index registers.

Every operand is taken from the state at the start of the cycle, and every result lands on the clock edge that closes it. A store whose source register is also the AND destination therefore sends the old register value to memory. An AND whose memory operand has the same address as the store sees the word as it was before the store.

The stage owns eight 32-bit integer registers and a 7-bit condition register. The auxiliary and index registers belong to the surrounding core and arrive as inputs. Other units can load the integer registers and the condition register through a shared load path. Memory sits outside the stage, behind one read port and one write port.

Top module: `lsx_exec`

## Requirements
- R1: When `ex_en` is high, the word executes only if bits [31:25] equal 7'b1101000 and both addressing-mode codes are supported. Otherwise `illegal` is high in that cycle, and no register, memory or condition write takes place.
- R2: The word fields are, from bit 24 down: destination register [24:22], AND register source [21:19], store register source [18:16], store address field [15:8] and AND memory address field [7:0]. Each address field is a 5-bit mode code above a 3-bit auxiliary register number.
- R3: An executed word writes register[src] AND memory[read address] into the destination register at the closing edge. `wb_we`, `wb_idx` and `wb_data` show this write during the cycle.
- R4: An executed word raises `mem_we` with `mem_wdata` equal to the store source register as it stood at the start of the cycle. This holds even when that register is the AND destination.
- R5: The read data is taken during the cycle and the store commits at the closing edge. When both addresses are equal, the AND therefore uses the memory word from before the store.
- R6: The mode code selects the displacement that is added to the chosen auxiliary register, and the sum is truncated to 24 bits. The codes are 5'b11000 for +0, 5'b00000 for +1, 5'b01000 for +index0 and 5'b10000 for +index1.
- R7: After an executed word, the N condition bit (status[3]) equals bit 31 of the AND result. The Z bit (status[2]) is 1 exactly when the result is zero.
- R8: After an executed word, UF (status[4]) and V (status[1]) are 0. LUF (status[6]), LV (status[5]) and C (status[0]) keep their previous values.
- R9: While `ex_en` is low, `illegal`, `mem_we` and `wb_we` are low, and no register or condition bit changes except through the load path.
- R10: With `pl_we` high, `pl_sel` 0–7 loads `pl_data` into that integer register, and `pl_sel` 8 loads `pl_data[6:0]` into the condition register. Any other select value has no effect. When an executed word writes the same target in the same cycle, the execute write wins.
- R11: Synchronous active-low reset clears all integer registers and the condition register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ex_en | input | 1 | Execute this cycle's instruction word |
| instr | input | 32 | Instruction word |
| ar_flat | input | 192 | Eight 24-bit auxiliary registers, register k at bits [24k+23:24k] |
| ir0 | input | 24 | Index register 0 |
| ir1 | input | 24 | Index register 1 |
| pl_we | input | 1 | Load-path write enable |
| pl_sel | input | 4 | Load-path target (0–7 registers, 8 condition register) |
| pl_data | input | 32 | Load-path data |
| mem_raddr | output | 24 | Read address for the AND operand |
| mem_rdata | input | 32 | Read data for `mem_raddr`, valid in the same cycle |
| mem_waddr | output | 24 | Store address |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Store strobe, committed at the closing edge |
| wb_we | output | 1 | Register write in this cycle |
| wb_idx | output | 3 | Register being written |
| wb_data | output | 32 | AND result being written |
| illegal | output | 1 | Enabled word not executable |
| status | output | 7 | Condition bits {LUF, LV, UF, N, Z, V, C} |

## Verification
A corrupted integer register surfaces at the ports the next time that register is used. If it is an AND source, `wb_data` is wrong in that same cycle. If it is a store source, `mem_wdata` is wrong. A bad condition bit appears on `status` one edge after the word that set it. The bench therefore compares every output on every clock against a behavioural model and reuses registers soon after writing them. Because of that, a lost or misdirected write shows up within a few cycles rather than at the end of the run.

// File: rtl/lsx_pkg.sv
// Package: shared encodings for the parallel AND-and-store execute stage.
// Assumes a 32-bit instruction word with fixed field positions.
package lsx_pkg;
    localparam int RIDX_W = 3;
    localparam int MODE_W = 5;
    localparam int NSTAT  = 7;

    localparam logic [6:0] OPC_AND_ST = 7'b1101000;

    // Supported indirect mode codes: add displacement, no pointer update
    localparam logic [MODE_W-1:0] AM_PLUS1   = 5'b00000;
    localparam logic [MODE_W-1:0] AM_PLUSIX0 = 5'b01000;
    localparam logic [MODE_W-1:0] AM_PLUSIX1 = 5'b10000;
    localparam logic [MODE_W-1:0] AM_PLUS0   = 5'b11000;

    // Condition register bit positions
    localparam int ST_LUF = 6;
    localparam int ST_LV  = 5;
    localparam int ST_UF  = 4;
    localparam int ST_N   = 3;
    localparam int ST_Z   = 2;
    localparam int ST_V   = 1;
    localparam int ST_C   = 0;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [RIDX_W-1:0] arn;
    } ind_t;

    typedef struct packed {
        logic              opc_ok;
        logic [RIDX_W-1:0] dst1;
        logic [RIDX_W-1:0] src1;
        logic [RIDX_W-1:0] src3;
        ind_t              dst2;
        ind_t              src2;
    } dec_t;
endpackage

// File: rtl/lsx_decode.sv
// Module: lsx_decode
// Splits an instruction word into its register and address fields and
// flags whether the major opcode matches. Purely combinational.
module lsx_decode
    import lsx_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    // Field extraction at fixed positions
    always_comb begin
        dec.opc_ok = (instr[31:25] == OPC_AND_ST);
        dec.dst1   = instr[24:22];
        dec.src1   = instr[21:19];
        dec.src3   = instr[18:16];
        dec.dst2   = instr[15:8];
        dec.src2   = instr[7:0];
    end
endmodule

// File: rtl/lsx_agen.sv
// Module: lsx_agen
// Forms an effective address from one auxiliary register plus a
// displacement chosen by the mode code. Assumes the auxiliary register
// bank arrives flattened, register k at bits [k*AW +: AW]. Any mode code
// outside the supported set drives ok low.
module lsx_agen
    import lsx_pkg::*;
#(
    parameter int AW  = 24,
    parameter int NAR = 8
) (
    input  ind_t              ind,
    input  logic [NAR*AW-1:0] ar_flat,
    input  logic [AW-1:0]     ir0,
    input  logic [AW-1:0]     ir1,
    output logic [AW-1:0]     ea,
    output logic              ok
);
    logic [AW-1:0] base;
    logic [AW-1:0] disp;

    // Select base register and displacement, add with truncation
    always_comb begin
        base = ar_flat[ind.arn*AW +: AW];
        ok   = 1'b1;
        case (ind.mode)
            AM_PLUS0:   disp = '0;
            AM_PLUS1:   disp = AW'(1);
            AM_PLUSIX0: disp = ir0;
            AM_PLUSIX1: disp = ir1;
            default: begin
                disp = '0;
                ok   = 1'b0;
            end
        endcase
        ea = base + disp;
    end
endmodule

// File: rtl/lsx_regfile.sv
// Module: lsx_regfile
// Integer register bank with two combinational read ports and two write
// sources: the execute result and the shared load path. Reads return the
// value held before the edge; on a same-index collision the execute write
// is applied last and wins.
module lsx_regfile #(
    parameter int DW   = 32,
    parameter int NREG = 8,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] ra_a,
    input  logic [IW-1:0] ra_b,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    input  logic          ex_we,
    input  logic [IW-1:0] ex_idx,
    input  logic [DW-1:0] ex_data,
    input  logic          pl_we,
    input  logic [IW-1:0] pl_idx,
    input  logic [DW-1:0] pl_data
);
    logic [DW-1:0] regs [NREG];

    // Start-of-cycle read ports
    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];

    // Register update: reset, then load path, then execute (priority last)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else begin
            if (pl_we) regs[pl_idx] <= pl_data;
            if (ex_we) regs[ex_idx] <= ex_data;
        end
    end

    // R3 / R10
    wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_we |=> regs[$past(ex_idx)] == $past(ex_data));
endmodule

// File: rtl/lsx_flags.sv
// Module: lsx_flags
// Condition register. An executed word sets N and Z from its result,
// clears UF and V and holds LUF, LV and C. Otherwise the load path may
// overwrite all seven bits. Execute takes priority over the load path.
module lsx_flags
    import lsx_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [DW-1:0]    res,
    input  logic             pl_we,
    input  logic [NSTAT-1:0] pl_data,
    output logic [NSTAT-1:0] st
);
    // Condition register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else if (upd) begin
            st[ST_N]  <= res[DW-1];
            st[ST_Z]  <= (res == '0);
            st[ST_UF] <= 1'b0;
            st[ST_V]  <= 1'b0;
        end else if (pl_we) begin
            st <= pl_data;
        end
    end

    // R7
    flag_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (st[ST_N] == $past(res[DW-1])) && (st[ST_Z] == ($past(res) == '0)));

    // R8
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !st[ST_UF] && !st[ST_V] && (st[ST_LUF] == $past(st[ST_LUF]))
                && (st[ST_LV] == $past(st[ST_LV])) && (st[ST_C] == $past(st[ST_C])));
endmodule

// File: rtl/lsx_exec.sv
// Module: lsx_exec
// Single-cycle execute stage for the parallel AND-and-store word.
// Assumes mem_rdata is valid for mem_raddr within the same cycle, and that
// external memory commits mem_wdata at the clock edge where mem_we is high.
// All operands are taken before the edge and all results land on it.
module lsx_exec
    import lsx_pkg::*;
#(
    parameter int DW   = 32,
    parameter int AW   = 24,
    parameter int NREG = 8,
    parameter int NAR  = 8,
    parameter int SELW = 4,
    localparam int IW  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ex_en,
    input  logic [31:0]       instr,
    input  logic [NAR*AW-1:0] ar_flat,
    input  logic [AW-1:0]     ir0,
    input  logic [AW-1:0]     ir1,
    input  logic              pl_we,
    input  logic [SELW-1:0]   pl_sel,
    input  logic [DW-1:0]     pl_data,
    output logic [AW-1:0]     mem_raddr,
    input  logic [DW-1:0]     mem_rdata,
    output logic [AW-1:0]     mem_waddr,
    output logic [DW-1:0]     mem_wdata,
    output logic              mem_we,
    output logic              wb_we,
    output logic [IW-1:0]     wb_idx,
    output logic [DW-1:0]     wb_data,
    output logic              illegal,
    output logic [NSTAT-1:0]  status
);
    localparam logic [SELW-1:0] SEL_STAT = SELW'(NREG);

    dec_t          dec;
    logic          rd_ok, wr_ok, legal, go;
    logic [DW-1:0] op_reg, st_reg, and_res;
    logic          pl_reg_we, pl_st_we;

    lsx_decode u_dec (.instr(instr), .dec(dec));

    // Two address generators: index 0 feeds the AND read, index 1 the store
    for (genvar g = 0; g < 2; g++) begin : g_agen
        logic [AW-1:0] ea;
        logic          ok;
        lsx_agen #(.AW(AW), .NAR(NAR)) u_agen (
            .ind     (g == 0 ? dec.src2 : dec.dst2),
            .ar_flat (ar_flat),
            .ir0     (ir0),
            .ir1     (ir1),
            .ea      (ea),
            .ok      (ok)
        );
    end

    // Legality and execute gating
    always_comb begin
        rd_ok   = g_agen[0].ok;
        wr_ok   = g_agen[1].ok;
        legal   = dec.opc_ok && rd_ok && wr_ok;
        go      = ex_en && legal;
        illegal = ex_en && !legal;
    end

    // Load-path target decode
    always_comb begin
        pl_reg_we = pl_we && (pl_sel < SELW'(NREG));
        pl_st_we  = pl_we && (pl_sel == SEL_STAT);
    end

    lsx_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_a    (dec.src1),
        .ra_b    (dec.src3),
        .rd_a    (op_reg),
        .rd_b    (st_reg),
        .ex_we   (go),
        .ex_idx  (dec.dst1),
        .ex_data (and_res),
        .pl_we   (pl_reg_we),
        .pl_idx  (pl_sel[IW-1:0]),
        .pl_data (pl_data)
    );

    // Logic operation on start-of-cycle operands
    assign and_res = op_reg & mem_rdata;

    // Memory port and write-back view
    always_comb begin
        mem_raddr = g_agen[0].ea;
        mem_waddr = g_agen[1].ea;
        mem_wdata = st_reg;
        mem_we    = go;
        wb_we     = go;
        wb_idx    = dec.dst1;
        wb_data   = and_res;
    end

    lsx_flags #(.DW(DW)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (go),
        .res     (and_res),
        .pl_we   (pl_st_we),
        .pl_data (pl_data[NSTAT-1:0]),
        .st      (status)
    );

    // R1
    no_wr_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !mem_we && !wb_we);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_en |-> !mem_we && !wb_we && !illegal);

    // R9
    idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_en && !pl_we) |=> $stable(status));
endmodule

// File: tb/lsx_exec_bench.sv
// Bench: behavioural model of registers, condition bits and memory,
// compared with every output on every cycle.
module lsx_exec_bench;
    localparam int AW = 24;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ex_en;
    logic [31:0] instr;
    logic [8*AW-1:0] ar_flat;
    logic [AW-1:0] ir0, ir1;
    logic        pl_we;
    logic [3:0]  pl_sel;
    logic [31:0] pl_data;
    logic [AW-1:0] mem_raddr, mem_waddr;
    logic [31:0] mem_rdata, mem_wdata;
    logic        mem_we, wb_we, illegal;
    logic [2:0]  wb_idx;
    logic [31:0] wb_data;
    logic [6:0]  status;

    logic [31:0] mem [256];
    logic [31:0] mR  [8];
    logic [6:0]  mSt;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    lsx_exec u_lsx_exec (
        .clk(clk), .rst_n(rst_n), .ex_en(ex_en), .instr(instr),
        .ar_flat(ar_flat), .ir0(ir0), .ir1(ir1),
        .pl_we(pl_we), .pl_sel(pl_sel), .pl_data(pl_data),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .wb_we(wb_we), .wb_idx(wb_idx), .wb_data(wb_data),
        .illegal(illegal), .status(status)
    );

    assign mem_rdata = mem[mem_raddr[7:0]];
    always @(posedge clk) if (mem_we) mem[mem_waddr[7:0]] <= mem_wdata;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int d1, input int s1, input int s3,
            input logic [4:0] dm, input int da, input logic [4:0] sm, input int sa);
        return {7'b1101000, 3'(d1), 3'(s1), 3'(s3), dm, 3'(da), sm, 3'(sa)};
    endfunction

    // R6: displacement per mode code
    function automatic logic disp_of(input logic [4:0] m, output logic [AW-1:0] d);
        d = '0;
        case (m)
            5'b11000: begin d = '0;    return 1'b1; end
            5'b00000: begin d = 24'd1; return 1'b1; end
            5'b01000: begin d = ir0;   return 1'b1; end
            5'b10000: begin d = ir1;   return 1'b1; end
            default:  return 1'b0;
        endcase
    endfunction

    task automatic step(input logic en, input logic [31:0] ins, input logic ple,
                        input logic [3:0] pls, input logic [31:0] pld, input string req);
        logic [AW-1:0] dr, dw, ear, eaw;
        logic okr, okw, lg, go;
        logic [31:0] res;
        int d1, s1, s3;
        @(negedge clk);
        ex_en = en; instr = ins; pl_we = ple; pl_sel = pls; pl_data = pld;
        #1;
        okr = disp_of(ins[7:3], dr);
        okw = disp_of(ins[15:11], dw);
        ear = ar_flat[ins[2:0]*AW +: AW] + dr;
        eaw = ar_flat[ins[10:8]*AW +: AW] + dw;
        lg  = (ins[31:25] == 7'b1101000) && okr && okw;
        go  = en && lg;
        d1 = int'(ins[24:22]); s1 = int'(ins[21:19]); s3 = int'(ins[18:16]);
        res = mR[s1] & mem[ear[7:0]];
        chk(req, "illegal", 32'(illegal), 32'(en && !lg));
        chk(req, "mem_we", 32'(mem_we), 32'(go));
        chk(req, "wb_we", 32'(wb_we), 32'(go));
        if (go) begin
            chk(req, "raddr", 32'(mem_raddr), 32'(ear));
            chk(req, "waddr", 32'(mem_waddr), 32'(eaw));
            chk(req, "wdata", mem_wdata, mR[s3]);
            chk(req, "wb_idx", 32'(wb_idx), 32'(d1));
            chk(req, "wb_data", wb_data, res);
        end
        @(posedge clk);
        #1;
        if (ple && pls < 4'd8) mR[pls[2:0]] = pld;
        if (go) begin
            mR[d1] = res;
            mSt[3] = res[31];
            mSt[2] = (res == 32'd0);
            mSt[4] = 1'b0;
            mSt[1] = 1'b0;
        end else if (ple && pls == 4'd8) begin
            mSt = pld[6:0];
        end
        chk(req, "status", 32'(status), 32'(mSt));
    endtask

    initial begin : watchdog
        #1000000;
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hA5000000 ^ (32'(i) * 32'h01010101);
        for (int i = 0; i < 8; i++) mR[i] = '0;
        mSt = '0;
        for (int i = 0; i < 7; i++) ar_flat[i*AW +: AW] = AW'(16 * i + 8);
        ar_flat[7*AW +: AW] = 24'hFFFFFF;
        ir0 = 24'd3; ir1 = 24'd5;
        ex_en = 0; instr = '0; pl_we = 0; pl_sel = '0; pl_data = '0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        chk("R11", "status", 32'(status), 32'd0);
        chk("R11", "mem_we", 32'(mem_we), 32'd0);
        @(negedge clk); rst_n = 1;

        // R10: load registers through the shared path
        for (int i = 0; i < 8; i++)
            step(0, '0, 1, 4'(i), 32'hFFFF0000 | (32'h1111 * 32'(i + 1)), "R10");
        // R10: unused select has no effect (visible via later stores)
        step(0, '0, 1, 4'd12, 32'hDEADBEEF, "R10");

        // R3 R6: each mode, both fields
        step(1, mk(0, 1, 2, 5'b11000, 1, 5'b11000, 0), 0, 0, 0, "R3");
        step(1, mk(3, 4, 5, 5'b00000, 2, 5'b00000, 3), 0, 0, 0, "R6");
        step(1, mk(5, 6, 7, 5'b01000, 4, 5'b10000, 5), 0, 0, 0, "R6");
        step(1, mk(6, 0, 3, 5'b10000, 6, 5'b01000, 2), 0, 0, 0, "R2");
        // R6: 24-bit wrap, AR7 + 1 -> 0
        step(1, mk(1, 2, 4, 5'b00000, 7, 5'b00000, 7), 0, 0, 0, "R6");
        // R4: store source equals AND destination
        step(1, mk(2, 3, 2, 5'b11000, 3, 5'b11000, 1), 0, 0, 0, "R4");
        step(1, mk(4, 2, 2, 5'b11000, 1, 5'b11000, 4), 0, 0, 0, "R4");
        // R5: same address for read and store, then read it back
        step(1, mk(7, 5, 1, 5'b00000, 2, 5'b00000, 2), 0, 0, 0, "R5");
        step(1, mk(0, 7, 6, 5'b11000, 3, 5'b00000, 2), 0, 0, 0, "R5");
        // R7: zero result (register cleared by load, then ANDed)
        step(0, '0, 1, 4'd1, 32'd0, "R10");
        step(1, mk(3, 1, 0, 5'b11000, 4, 5'b11000, 5), 0, 0, 0, "R7");
        step(1, mk(3, 6, 0, 5'b11000, 4, 5'b11000, 6), 0, 0, 0, "R7");
        // R8: preload LUF, LV, C, UF, V then execute
        step(0, '0, 1, 4'd8, 32'h0000007F, "R8");
        step(1, mk(5, 4, 3, 5'b11000, 2, 5'b11000, 1), 0, 0, 0, "R8");
        step(0, '0, 1, 4'd8, 32'h00000012, "R8");
        step(1, mk(5, 0, 3, 5'b00000, 0, 5'b01000, 5), 0, 0, 0, "R8");
        // R1: bad mode code on either field, and bad opcode
        step(1, mk(1, 2, 3, 5'b00101, 1, 5'b11000, 2), 0, 0, 0, "R1");
        step(1, mk(1, 2, 3, 5'b11000, 1, 5'b11111, 2), 0, 0, 0, "R1");
        step(1, mk(1, 2, 3, 5'b11000, 1, 5'b11000, 2) ^ 32'h02000000, 0, 0, 0, "R1");
        // R9: disabled word with valid encoding
        step(0, mk(1, 2, 3, 5'b11000, 1, 5'b11000, 2), 0, 0, 0, "R9");
        // R10: collision, execute wins for register and condition bits
        step(1, mk(2, 5, 6, 5'b11000, 1, 5'b11000, 3), 1, 4'd2, 32'h12345678, "R10");
        step(1, mk(4, 6, 7, 5'b11000, 2, 5'b11000, 5), 1, 4'd8, 32'h0000007F, "R10");
        // Reveal all registers through stores (R9 R10 state)
        for (int i = 0; i < 8; i++)
            step(1, mk(i, i, i, 5'b11000, 6, 5'b11000, 0), 0, 0, 0, "R4");
        step(0, '0, 0, 0, 0, "R9");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule